// File: doc/BRIEF.md
# Timer-Triggered Pattern Output Unit

This block drives a 16-bit output pattern. A next-data register holds the values the pattern should take next. A timer compare-match pulse copies those values into the output latch. The outputs are split into four nibble groups. Each group picks one of four compare-match channels as its trigger, and each output bit has its own transfer enable. Several timers can therefore step independent pattern sequences on different parts of the same port.

Software loads the next-data, enable and trigger-select registers over a simple single-cycle register bus. The output latch can be read back over the same bus. This bus and the pattern output carry no stream of data that can be stalled, so neither has a valid/ready handshake. A write takes effect at the clock edge it is presented on, and read data is a combinational function of the address.

When the standby input is high, the block behaves as if the timers were stopped. Compare-match pulses are ignored and every register keeps its contents.

Top module: `pattern_unit`

## Requirements
- R1: After reset, the output latch, the next-data register and the enable register read 0x0000.
- R2: After reset, the trigger-select register reads 0x00FF, so every group starts on channel 3.
- R3: Pattern bits 15:12 form group 3, 11:8 group 2, 7:4 group 1 and 3:0 group 0. Trigger-select bits 7:6 choose the trigger for group 3, 5:4 for group 2, 3:2 for group 1 and 1:0 for group 0.
- R4: A select value of n (0 to 3) makes its group transfer on a pulse of compare-match input bit n, and on no other pulse.
- R5: On a trigger, an output bit with enable 1 takes its next-data bit. An output bit with enable 0 keeps its value.
- R6: All groups whose selected channel pulses in a cycle update at the same clock edge, including when several channels pulse together.
- R7: If a next-data write and a triggering pulse fall in the same cycle, the transfer uses the next-data value from before the write.
- R8: While standby is high, compare-match pulses cause no transfer and the registers keep their contents.
- R9: Register addresses: 0 = next-data, 1 = enable, 2 = trigger-select (bits 15:8 read 0), 3 = output latch (read only). Written values read back unchanged.
- R10: The output changes at the clock edge that samples the pulse. It stays stable in any cycle with no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| standby | input | 1 | Stops transfers while high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| cm_i | input | 4 | Compare-match pulses, one bit per timer channel |
| pat_o | output | 16 | Pattern output latch |

## Verification
The bench builds the block with its default values: four groups of four bits and four channels. With these values, every select code and every channel can be reached by a directed pulse, and each group can sit on a different channel at once. The fixed field positions in the trigger-select register can then be checked against a per-group model of the output latch. The bench also checks a same-cycle write and trigger, enable masks that split groups, and pulses sent during standby.

// File: rtl/pu_pkg.sv
package pu_pkg;
  typedef enum logic [1:0] {
    A_NEXT = 2'd0,
    A_EN   = 2'd1,
    A_TSEL = 2'd2,
    A_PAT  = 2'd3
  } pu_addr_e;
endpackage

// File: rtl/pu_regfile.sv
module pu_regfile #(
  parameter int DW  = 16,
  parameter int TSW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  nd_q,
  output logic [DW-1:0]  en_q,
  output logic [TSW-1:0] tsel_q
);
  import pu_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nd_q   <= '0;
      en_q   <= '0;
      tsel_q <= '1;
    end else if (wr_en) begin
      case (pu_addr_e'(addr))
        A_NEXT:  nd_q   <= wdata;
        A_EN:    en_q   <= wdata;
        A_TSEL:  tsel_q <= wdata[TSW-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pu_group.sv
module pu_group #(
  parameter int GW       = 4,
  parameter int CHANNELS = 4,
  localparam int SEL_W   = $clog2(CHANNELS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] cm,
  input  logic [SEL_W-1:0]    sel,
  input  logic [GW-1:0]       en,
  input  logic [GW-1:0]       nd,
  output logic [GW-1:0]       q
);
  logic trig;
  assign trig = cm[sel];

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (trig) q <= (q & ~en) | (nd & en);
  end
endmodule

// File: rtl/pattern_unit.sv
module pattern_unit #(
  parameter int GROUPS   = 4,
  parameter int GROUP_W  = 4,
  parameter int CHANNELS = 4,
  localparam int SEL_W   = $clog2(CHANNELS),
  localparam int DW      = GROUPS * GROUP_W,
  localparam int TSW     = GROUPS * SEL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                standby,
  input  logic                wr_en,
  input  logic [1:0]          addr,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rdata,
  input  logic [CHANNELS-1:0] cm_i,
  output logic [DW-1:0]       pat_o
);
  import pu_pkg::*;

  logic [DW-1:0]       nd_q, en_q;
  logic [TSW-1:0]      tsel_q;
  logic [CHANNELS-1:0] cm_act;

  assign cm_act = standby ? '0 : cm_i;

  pu_regfile #(.DW(DW), .TSW(TSW)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .nd_q(nd_q), .en_q(en_q), .tsel_q(tsel_q)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    pu_group #(.GW(GROUP_W), .CHANNELS(CHANNELS)) i_grp (
      .clk(clk), .rst_n(rst_n), .cm(cm_act),
      .sel(tsel_q[g*SEL_W +: SEL_W]),
      .en(en_q[g*GROUP_W +: GROUP_W]),
      .nd(nd_q[g*GROUP_W +: GROUP_W]),
      .q(pat_o[g*GROUP_W +: GROUP_W])
    );
  end

  always_comb begin
    case (pu_addr_e'(addr))
      A_NEXT:  rdata = nd_q;
      A_EN:    rdata = en_q;
      A_TSEL:  rdata = {{(DW-TSW){1'b0}}, tsel_q};
      default: rdata = pat_o;
    endcase
  end
endmodule

// File: rtl/pu_chk.sv
module pu_chk #(
  parameter int GROUPS   = 4,
  parameter int GROUP_W  = 4,
  parameter int CHANNELS = 4,
  localparam int SEL_W   = $clog2(CHANNELS),
  localparam int DW      = GROUPS * GROUP_W,
  localparam int TSW     = GROUPS * SEL_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                standby,
  input logic                wr_en,
  input logic [1:0]          addr,
  input logic [CHANNELS-1:0] cm_i,
  input logic [DW-1:0]       nd,
  input logic [DW-1:0]       en,
  input logic [TSW-1:0]      tsel,
  input logic [DW-1:0]       pat
);
  // R10
  no_pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_i == '0) |=> $stable(pat));

  // R5
  disabled_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pat ^ $past(pat)) & ~$past(en)) == '0));

  // R8
  standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> $stable(pat));

  // R8
  tsel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 2'd2) |=> $stable(tsel));

  for (genvar g = 0; g < GROUPS; g++) begin : g_c
    // R7
    xfer_old_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!standby && cm_i[tsel[g*SEL_W +: SEL_W]]) |=>
        (((pat[g*GROUP_W +: GROUP_W] ^ $past(nd[g*GROUP_W +: GROUP_W]))
          & $past(en[g*GROUP_W +: GROUP_W])) == '0));
  end
endmodule

bind pattern_unit pu_chk #(.GROUPS(GROUPS), .GROUP_W(GROUP_W), .CHANNELS(CHANNELS)) i_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby), .wr_en(wr_en), .addr(addr),
  .cm_i(cm_i), .nd(nd_q), .en(en_q), .tsel(tsel_q), .pat(pat_o)
);

// File: tb/test_pattern_unit.sv
module test_pattern_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  cm_i = '0;
  logic [15:0] pat_o;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pattern_unit i_pattern_unit (
    .clk(clk), .rst_n(rst_n), .standby(standby), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cm_i(cm_i), .pat_o(pat_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse(input logic [3:0] c);
    @(negedge clk);
    cm_i = c;
    @(negedge clk);
    cm_i = '0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2'd0, d); chk("R1 next-data", d, 16'h0000);
    rd(2'd1, d); chk("R1 enable", d, 16'h0000);
    rd(2'd3, d); chk("R1 latch", d, 16'h0000);
    chk("R1 pat_o", pat_o, 16'h0000);
    rd(2'd2, d); chk("R2 tsel", d, 16'h00FF);
  endtask

  task automatic t_disabled();
    wr(2'd0, 16'hFFFF);
    pulse(4'hF);
    chk("R5 all disabled", pat_o, 16'h0000);
  endtask

  task automatic t_default_channel();
    wr(2'd1, 16'hFFFF);
    pulse(4'b0001);
    chk("R4 channel 0 ignored", pat_o, 16'h0000);
    pulse(4'b1000);
    chk("R2 channel 3 default", pat_o, 16'hFFFF);
  endtask

  task automatic t_groups();
    logic [15:0] d;
    wr(2'd2, 16'h001B);
    rd(2'd2, d); chk("R9 tsel readback", d, 16'h001B);
    wr(2'd0, 16'h1234);
    pulse(4'b0010); chk("R3 group2 on ch1", pat_o, 16'hF2FF);
    pulse(4'b0001); chk("R3 group3 on ch0", pat_o, 16'h12FF);
    pulse(4'b0100); chk("R3 group1 on ch2", pat_o, 16'h123F);
    pulse(4'b1000); chk("R4 group0 on ch3", pat_o, 16'h1234);
  endtask

  task automatic t_timing();
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd0; wdata = 16'h4321;
    @(negedge clk);
    wr_en = 1'b0;
    cm_i = 4'b1111;
    chk("R10 before edge", pat_o, 16'h1234);
    @(negedge clk);
    cm_i = '0;
    chk("R10 after edge", pat_o, 16'h4321);
    @(negedge clk);
    chk("R10 no pulse hold", pat_o, 16'h4321);
  endtask

  task automatic t_mask();
    logic [15:0] d;
    wr(2'd1, 16'h0F0F);
    rd(2'd1, d); chk("R9 enable readback", d, 16'h0F0F);
    wr(2'd0, 16'hABCD);
    wr(2'd2, 16'h00FF);
    pulse(4'b1000);
    chk("R5 masked transfer", pat_o, 16'h4B2D);
  endtask

  task automatic t_multi();
    wr(2'd1, 16'hFFFF);
    wr(2'd2, 16'h0050);
    wr(2'd0, 16'h5555);
    pulse(4'b0011);
    chk("R6 two channels together", pat_o, 16'h5555);
    wr(2'd0, 16'hAAAA);
    pulse(4'b0001);
    chk("R6 groups on ch0 only", pat_o, 16'h55AA);
    pulse(4'b0010);
    chk("R6 groups on ch1", pat_o, 16'hAAAA);
  endtask

  task automatic t_same_cycle();
    logic [15:0] d;
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd0; wdata = 16'h0F0F; cm_i = 4'b0011;
    @(negedge clk);
    wr_en = 1'b0; cm_i = '0;
    chk("R7 old data used", pat_o, 16'hAAAA);
    rd(2'd0, d); chk("R7 write landed", d, 16'h0F0F);
    pulse(4'b0011);
    chk("R7 new data next", pat_o, 16'h0F0F);
  endtask

  task automatic t_standby();
    logic [15:0] d;
    wr(2'd0, 16'h3C3C);
    @(negedge clk);
    standby = 1'b1;
    pulse(4'hF);
    chk("R8 no transfer in standby", pat_o, 16'h0F0F);
    rd(2'd2, d); chk("R8 tsel kept", d, 16'h0050);
    rd(2'd0, d); chk("R8 next-data kept", d, 16'h3C3C);
    @(negedge clk);
    standby = 1'b0;
    pulse(4'b0001);
    chk("R8 resumes after standby", pat_o, 16'h0F3C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_disabled();
    t_default_channel();
    t_groups();
    t_timing();
    t_mask();
    t_multi();
    t_same_cycle();
    t_standby();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule